// File: doc/BRIEF.md
# Pad Standby Override

This block sits between a pad controller and a bank of general-purpose pads. In normal operation it registers the controller's transmit value, transmit enable and pull settings toward the pads. It also registers each pad's input back toward the controller. When the shared standby request is high, each pad lane looks at its own 4-bit standby-state code. That code can replace the driver value, the driver enable and the value returned to the controller. A separate 2-bit per-lane termination code replaces the pull-up and pull-down controls for as long as the request is high.

The standby-state codes combine one drive choice with one receive choice. The drive choice is the value held from before standby, a constant 0, a constant 1, or driver off. The receive choice is either the live pad input or a constant returned to the controller in its place. Codes 10 to 15 leave the normal path in force. Every output is a flop, so any change at the inputs shows at the outputs one clock later.

Top module: `pad_stby_ovr`

## Requirements
- R1: While `rst` is high at a clock edge, every output bit is 0 after that edge.
- R2: With `stby_req` low at an edge, after that edge each lane shows the sampled values: `pad_out` = `tx_data`, `pad_oe` = `tx_en`, `rx_val` = `pad_in`, `pull_up` = `pull_up_cfg`, `pull_dn` = `pull_dn_cfg`.
- R3: State code 0 (bits [4p+3:4p] of `stby_code` for lane p) sets `pad_oe` = 1 and `rx_val` = `pad_in`. `pad_out` holds the value `pad_out` had just before the edge at which `stby_req` was first seen high, and keeps it while the request stays high.
- R4: State codes 1, 2, 3 and 4 set `pad_oe` = 1 and fix the pair (`pad_out`, `rx_val`) at (0,0), (0,1), (1,0) and (1,1) respectively.
- R5: State codes 5 and 6 set `pad_oe` = 1 with `pad_out` at 0 and 1 respectively, and `rx_val` = `pad_in`.
- R6: State codes 7 and 8 set `pad_oe` = 0 and `pad_out` = 0, with `rx_val` fixed at 0 and 1 respectively.
- R7: State code 9 sets `pad_oe` = 0 and `pad_out` = 0, with `rx_val` = `pad_in`.
- R8: State codes 10 to 15 leave the transmit and receive paths exactly as in R2 even while `stby_req` is high.
- R9: While `stby_req` is high, termination code (bits [2p+1:2p] of `term_code`) 0 passes the configured pulls, 1 clears both pulls, 2 gives `pull_dn` = 1 and `pull_up` = 0, and 3 gives `pull_up` = 1 and `pull_dn` = 0. This applies whatever the state code.
- R10: The first edge with `stby_req` low after standby restores the R2 behaviour for every output.
- R11: Each lane follows only its own codes and data. Lanes given different codes in the same cycle do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_req | input | 1 | Standby request shared by all lanes |
| stby_code | input | 4*NUM_PADS | Per-lane standby-state code |
| term_code | input | 2*NUM_PADS | Per-lane standby termination code |
| tx_data | input | NUM_PADS | Normal transmit value |
| tx_en | input | NUM_PADS | Normal transmit enable |
| pull_up_cfg | input | NUM_PADS | Normal pull-up setting |
| pull_dn_cfg | input | NUM_PADS | Normal pull-down setting |
| pad_in | input | NUM_PADS | Value sensed at the pad |
| pad_out | output | NUM_PADS | Driver value toward the pad |
| pad_oe | output | NUM_PADS | Driver enable toward the pad |
| rx_val | output | NUM_PADS | Value returned to the controller |
| pull_up | output | NUM_PADS | Pull-up enable |
| pull_dn | output | NUM_PADS | Pull-down enable |

## Verification
The capture of the held drive value and the first standby override happen at the same clock edge: the edge where the request rises. The bench provokes this by raising `stby_req` with state code 0 in the same cycle that `tx_data` flips. It then checks that `pad_out` keeps the value registered before that edge and ignores the new transmit value. The termination override and the state override also act at the same edge. Random runs mix both codes per lane, and a bench model computes every output bit independently.

// File: rtl/pad_stby_pkg.sv
package pad_stby_pkg;

  localparam int CODE_W = 4;
  localparam int TERM_W = 2;

  // Drive choice taken from a standby-state code
  typedef enum logic [1:0] {
    DRV_HELD = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2,
    DRV_OFF  = 2'd3
  } drv_sel_e;

  // Termination choice during standby
  typedef enum logic [1:0] {
    TERM_KEEP = 2'd0,
    TERM_NONE = 2'd1,
    TERM_DOWN = 2'd2,
    TERM_UP   = 2'd3
  } term_sel_e;

  typedef struct packed {
    logic     overrides;  // code takes effect when standby is requested
    drv_sel_e drv;
    logic     rx_fixed;   // receive value replaced by rx_level
    logic     rx_level;
  } stby_act_t;

endpackage

// File: rtl/pad_stby_decode.sv
module pad_stby_decode
  import pad_stby_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output stby_act_t         act
);

  always_comb begin
    act.overrides = 1'b1;
    act.drv       = DRV_HELD;
    act.rx_fixed  = 1'b0;
    act.rx_level  = 1'b0;
    case (code)
      4'd0: act.drv = DRV_HELD;
      4'd1: begin act.drv = DRV_LOW;  act.rx_fixed = 1'b1; act.rx_level = 1'b0; end
      4'd2: begin act.drv = DRV_LOW;  act.rx_fixed = 1'b1; act.rx_level = 1'b1; end
      4'd3: begin act.drv = DRV_HIGH; act.rx_fixed = 1'b1; act.rx_level = 1'b0; end
      4'd4: begin act.drv = DRV_HIGH; act.rx_fixed = 1'b1; act.rx_level = 1'b1; end
      4'd5: act.drv = DRV_LOW;
      4'd6: act.drv = DRV_HIGH;
      4'd7: begin act.drv = DRV_OFF;  act.rx_fixed = 1'b1; act.rx_level = 1'b0; end
      4'd8: begin act.drv = DRV_OFF;  act.rx_fixed = 1'b1; act.rx_level = 1'b1; end
      4'd9: act.drv = DRV_OFF;
      default: act.overrides = 1'b0;  // 10..15: standby ignored
    endcase
  end

endmodule

// File: rtl/pad_stby_term.sv
module pad_stby_term
  import pad_stby_pkg::*;
(
  input  logic              active,
  input  logic [TERM_W-1:0] term,
  input  logic              up_cfg,
  input  logic              dn_cfg,
  output logic              up_nxt,
  output logic              dn_nxt
);

  term_sel_e sel;
  assign sel = term_sel_e'(term);

  always_comb begin
    up_nxt = up_cfg;
    dn_nxt = dn_cfg;
    if (active) begin
      case (sel)
        TERM_NONE: begin up_nxt = 1'b0; dn_nxt = 1'b0; end
        TERM_DOWN: begin up_nxt = 1'b0; dn_nxt = 1'b1; end
        TERM_UP:   begin up_nxt = 1'b1; dn_nxt = 1'b0; end
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/pad_stby_lane.sv
module pad_stby_lane
  import pad_stby_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_req,
  input  logic [CODE_W-1:0] code,
  input  logic [TERM_W-1:0] term,
  input  logic              tx_data,
  input  logic              tx_en,
  input  logic              up_cfg,
  input  logic              dn_cfg,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              rx_val,
  output logic              pull_up,
  output logic              pull_dn
);

  stby_act_t act;
  logic      req_q;
  logic      held_q;
  logic      held_nxt;
  logic      out_nxt, oe_nxt, rx_nxt, up_nxt, dn_nxt;

  pad_stby_decode u_dec (.code(code), .act(act));

  pad_stby_term u_term (
    .active (stby_req),
    .term   (term),
    .up_cfg (up_cfg),
    .dn_cfg (dn_cfg),
    .up_nxt (up_nxt),
    .dn_nxt (dn_nxt)
  );

  // Value on the driver just before the request's first edge is kept
  assign held_nxt = (stby_req && !req_q) ? pad_out : held_q;

  always_comb begin
    out_nxt = tx_data;
    oe_nxt  = tx_en;
    rx_nxt  = pad_in;
    if (stby_req && act.overrides) begin
      case (act.drv)
        DRV_HELD: begin out_nxt = held_nxt; oe_nxt = 1'b1; end
        DRV_LOW:  begin out_nxt = 1'b0;     oe_nxt = 1'b1; end
        DRV_HIGH: begin out_nxt = 1'b1;     oe_nxt = 1'b1; end
        default:  begin out_nxt = 1'b0;     oe_nxt = 1'b0; end
      endcase
      rx_nxt = act.rx_fixed ? act.rx_level : pad_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      held_q  <= 1'b0;
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      rx_val  <= 1'b0;
      pull_up <= 1'b0;
      pull_dn <= 1'b0;
    end else begin
      req_q   <= stby_req;
      held_q  <= held_nxt;
      pad_out <= out_nxt;
      pad_oe  <= oe_nxt;
      rx_val  <= rx_nxt;
      pull_up <= up_nxt;
      pull_dn <= dn_nxt;
    end
  end

  // Assertions
  p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    !stby_req |=> (pad_out == $past(tx_data)) && (pad_oe == $past(tx_en))
                  && (rx_val == $past(pad_in)));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (stby_req && $past(stby_req) && code == 4'd0 && $past(code) == 4'd0)
      |=> $stable(pad_out) && pad_oe);

  p_hiz_fixed_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (stby_req && (code == 4'd7 || code == 4'd8))
      |=> !pad_oe && (rx_val == ($past(code) == 4'd8)));

  p_ignore_code_r8: assert property (@(posedge clk) disable iff (rst)
    (stby_req && code >= 4'd10)
      |=> (pad_out == $past(tx_data)) && (pad_oe == $past(tx_en)));

  p_term_none_r9: assert property (@(posedge clk) disable iff (rst)
    (stby_req && term == 2'd1) |=> !pull_up && !pull_dn);

  p_term_excl_r9: assert property (@(posedge clk) disable iff (rst)
    (stby_req && term[1]) |=> $onehot0({pull_up, pull_dn}) && (pull_up || pull_dn));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (!stby_req && $past(stby_req))
      |=> (pull_up == $past(up_cfg)) && (pull_dn == $past(dn_cfg)));

endmodule

// File: rtl/pad_stby_ovr.sv
module pad_stby_ovr
  import pad_stby_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stby_req,
  input  logic [CODE_W*NUM_PADS-1:0] stby_code,
  input  logic [TERM_W*NUM_PADS-1:0] term_code,
  input  logic [NUM_PADS-1:0]        tx_data,
  input  logic [NUM_PADS-1:0]        tx_en,
  input  logic [NUM_PADS-1:0]        pull_up_cfg,
  input  logic [NUM_PADS-1:0]        pull_dn_cfg,
  input  logic [NUM_PADS-1:0]        pad_in,
  output logic [NUM_PADS-1:0]        pad_out,
  output logic [NUM_PADS-1:0]        pad_oe,
  output logic [NUM_PADS-1:0]        rx_val,
  output logic [NUM_PADS-1:0]        pull_up,
  output logic [NUM_PADS-1:0]        pull_dn
);

  // R11: one independent lane per pad
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_lane
    pad_stby_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .stby_req (stby_req),
      .code     (stby_code[p*CODE_W +: CODE_W]),
      .term     (term_code[p*TERM_W +: TERM_W]),
      .tx_data  (tx_data[p]),
      .tx_en    (tx_en[p]),
      .up_cfg   (pull_up_cfg[p]),
      .dn_cfg   (pull_dn_cfg[p]),
      .pad_in   (pad_in[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .rx_val   (rx_val[p]),
      .pull_up  (pull_up[p]),
      .pull_dn  (pull_dn[p])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pad_out == '0) && (pad_oe == '0) && (rx_val == '0)
            && (pull_up == '0) && (pull_dn == '0));

endmodule

// File: tb/sim_pad_stby_ovr.sv
module sim_pad_stby_ovr;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic            rst;
  logic            stby_req;
  logic [4*NP-1:0] stby_code;
  logic [2*NP-1:0] term_code;
  logic [NP-1:0]   tx_data, tx_en, pull_up_cfg, pull_dn_cfg, pad_in;
  logic [NP-1:0]   pad_out, pad_oe, rx_val, pull_up, pull_dn;

  pad_stby_ovr #(.NUM_PADS(NP)) u0 (
    .clk(clk), .rst(rst), .stby_req(stby_req), .stby_code(stby_code),
    .term_code(term_code), .tx_data(tx_data), .tx_en(tx_en),
    .pull_up_cfg(pull_up_cfg), .pull_dn_cfg(pull_dn_cfg), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .rx_val(rx_val),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  // Bench model state
  logic m_out [NP];
  logic m_held[NP];
  logic m_req;
  // Expected values for the coming edge
  logic e_out[NP], e_oe[NP], e_rx[NP], e_up[NP], e_dn[NP], e_held[NP];
  string e_tag[NP], e_ptag[NP];

  task automatic chk(string tag, int pad, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pad %0d %s actual %b expected %b", tag, pad, what, act, exp);
    end
  endtask

  task automatic predict();
    for (int p = 0; p < NP; p++) begin
      logic [3:0] c;
      logic [1:0] t;
      logic       held;
      c = stby_code[4*p +: 4];
      t = term_code[2*p +: 2];
      held = (stby_req && !m_req) ? m_out[p] : m_held[p];
      e_out[p] = tx_data[p]; e_oe[p] = tx_en[p]; e_rx[p] = pad_in[p];
      e_up[p] = pull_up_cfg[p]; e_dn[p] = pull_dn_cfg[p];
      e_tag[p] = m_req ? "R10" : "R2";
      if (stby_req) begin
        e_tag[p] = "R8";
        case (c)
          4'd0: begin e_out[p] = held; e_oe[p] = 1; e_tag[p] = "R3"; end
          4'd1: begin e_out[p] = 0; e_oe[p] = 1; e_rx[p] = 0; e_tag[p] = "R4"; end
          4'd2: begin e_out[p] = 0; e_oe[p] = 1; e_rx[p] = 1; e_tag[p] = "R4"; end
          4'd3: begin e_out[p] = 1; e_oe[p] = 1; e_rx[p] = 0; e_tag[p] = "R4"; end
          4'd4: begin e_out[p] = 1; e_oe[p] = 1; e_rx[p] = 1; e_tag[p] = "R4"; end
          4'd5: begin e_out[p] = 0; e_oe[p] = 1; e_tag[p] = "R5"; end
          4'd6: begin e_out[p] = 1; e_oe[p] = 1; e_tag[p] = "R5"; end
          4'd7: begin e_out[p] = 0; e_oe[p] = 0; e_rx[p] = 0; e_tag[p] = "R6"; end
          4'd8: begin e_out[p] = 0; e_oe[p] = 0; e_rx[p] = 1; e_tag[p] = "R6"; end
          4'd9: begin e_out[p] = 0; e_oe[p] = 0; e_tag[p] = "R7"; end
          default: ;
        endcase
        case (t)
          2'd1: begin e_up[p] = 0; e_dn[p] = 0; end
          2'd2: begin e_up[p] = 0; e_dn[p] = 1; end
          2'd3: begin e_up[p] = 1; e_dn[p] = 0; end
          default: ;
        endcase
      end
      e_ptag[p] = stby_req ? "R9" : e_tag[p];
      e_held[p] = held;
      if (rst) begin
        e_out[p] = 0; e_oe[p] = 0; e_rx[p] = 0; e_up[p] = 0; e_dn[p] = 0;
        e_held[p] = 0; e_tag[p] = "R1"; e_ptag[p] = "R1";
      end
    end
  endtask

  // One clock: predict, let the edge pass, sample 1 ns later, advance model
  task automatic step();
    logic req_now;
    req_now = rst ? 1'b0 : stby_req;
    predict();
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      chk(e_tag[p],  p, "pad_out", pad_out[p], e_out[p]);
      chk(e_tag[p],  p, "pad_oe",  pad_oe[p],  e_oe[p]);
      chk(e_tag[p],  p, "rx_val",  rx_val[p],  e_rx[p]);
      chk(e_ptag[p], p, "pull_up", pull_up[p], e_up[p]);
      chk(e_ptag[p], p, "pull_dn", pull_dn[p], e_dn[p]);
      m_out[p]  = e_out[p];
      m_held[p] = e_held[p];
    end
    m_req = req_now;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) begin m_out[p] = 0; m_held[p] = 0; end
    m_req = 0;
    rst = 1; stby_req = 0; stby_code = '1; term_code = '0;
    tx_data = '1; tx_en = '1; pull_up_cfg = '1; pull_dn_cfg = '0; pad_in = '1;
    // R1: reset state
    repeat (3) step();
    rst = 0;

    // R2: normal path with several patterns
    for (int i = 0; i < 6; i++) begin
      tx_data = NP'(i * 5); tx_en = NP'(~i); pad_in = NP'(i * 3);
      pull_up_cfg = NP'(i); pull_dn_cfg = NP'(i >> 1);
      step();
    end

    // R3: request rises in the same cycle tx_data flips
    tx_data = 4'b1010; step();
    stby_code = '0; term_code = '0;
    stby_req = 1; tx_data = 4'b0101; pad_in = 4'b0011; step();
    tx_data = 4'b1111; step();
    tx_data = 4'b0000; pad_in = 4'b1100; step();
    // R10: release
    stby_req = 0; step(); step();

    // R4..R8, R11: every code, lanes rotated so each carries a different one
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < NP; p++) stby_code[4*p +: 4] = 4'((c + p * 5) % 16);
      term_code = 8'(c * 37);
      tx_data = NP'(c); stby_req = 1; step();
      for (int k = 0; k < 3; k++) begin
        tx_data = NP'($urandom); tx_en = NP'($urandom); pad_in = NP'($urandom);
        step();
      end
      stby_req = 0; step();
    end

    // R9: every termination code on every lane
    for (int t = 0; t < 4; t++) begin
      term_code = {NP{2'(t)}};
      pull_up_cfg = 4'b0101; pull_dn_cfg = 4'b0011;
      stby_req = 1; step(); step();
      stby_req = 0; step();
    end

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) stby_req = ~stby_req;
      if ($urandom % 4 == 0) stby_code = 16'($urandom);
      if ($urandom % 4 == 0) term_code = 8'($urandom);
      tx_data = NP'($urandom); tx_en = NP'($urandom); pad_in = NP'($urandom);
      pull_up_cfg = NP'($urandom); pull_dn_cfg = NP'($urandom);
      if ($urandom % 500 == 0) rst = 1;
      step();
      rst = 0;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule